// File: doc/BRIEF.md
# Round-Robin Sensor Polling Master

This block is a host-side serial master that keeps a four-source sensor front end busy. It issues an endless sequence of 16-clock, mode 0 serial frames. Each frame selects one of four sources (angular rate, temperature, first auxiliary input, second auxiliary input) in fixed rotation. The sensor interface is pipelined, so the word that comes back in a frame holds the sample configured by the frame before it. The master keeps track of that one-frame lag and checks the address tag in each reply against the source it expects. It turns the 12-bit result into a signed value and hands it out on a valid/ready port together with the channel number.

The serial clock half period and the chip-select idle gap between frames are runtime inputs. The half period is held to a parameterised floor, so the serial clock can never run faster than the attached sensor allows. The coding chosen for each command is stored, and the reply one frame later is decoded with that same coding. When a reply has the wrong tag, the sample is dropped and a one-cycle error flag is raised. When the result port stalls, the next frame does not start until the held sample has been taken.

Top module: `spoll_master`

## Requirements
- R1: While reset is asserted, chip select is high, the serial clock is low, and neither the result valid output nor the error flag is asserted.
- R2: Every frame has exactly 16 serial clock pulses while chip select is low. The serial clock is low whenever chip select is high and idles low (mode 0). The master changes its data output after falling edges and samples the reply on rising edges, most significant bit first.
- R3: The command word sent in each frame is laid out as follows. Bit 15 is 1. Bits 14:12 are 0. Bits 11:10 hold the source code. Bits 9:8 are 11. Bits 7:5 are 0. Bit 4 holds the coding flag as sampled at frame start (1 = offset binary, 0 = twos complement). Bits 3:0 are 0.
- R4: Frames command sources 0, 1, 2, 3, 0, … starting after reset. A reply is attributed to the source commanded one frame earlier. The first reply after reset is discarded without raising an error, so the first result carries channel 0.
- R5: A reply is accepted only when its bits 15:14 are 00 and its tag in bits 13:12 equals the expected source. Otherwise the sample is dropped, and the error flag is high for exactly one clock cycle. Polling continues with the next source.
- R6: The result is the 12-bit field (bits 11:0) converted to a signed value. Under offset binary the result is the field minus 2048. Under twos complement the field is sign-extended from bit 11. The coding used is the one sent in the command of the preceding frame.
- R7: Once valid, the result keeps its channel and value unchanged until accepted with ready. While a result is waiting, chip select stays high and no new frame starts.
- R8: Each serial clock high and low phase lasts max(half-period input, MIN_HALF) system clocks.
- R9: Between frames, chip select stays high for at least the gap input plus one clock cycles. This is exactly that long when the result port accepts at once and the gap exceeds the handshake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div_i | input | DIV_W | Serial clock half period in system clocks (floored at MIN_HALF) |
| gap_i | input | GAP_W | Extra chip-select idle cycles between frames |
| offset_bin_i | input | 1 | Coding requested in the next command: 1 offset binary, 0 twos complement |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select framing each transfer |
| mosi_o | output | 1 | Serial command data to the sensor |
| miso_i | input | 1 | Serial reply data from the sensor |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result accepted by the consumer |
| res_chan_o | output | 2 | Source of the result (0 rate, 1 temperature, 2 aux 1, 3 aux 2) |
| res_value_o | output | DATA_W | Signed result |
| seq_err_o | output | 1 | One-cycle pulse when a reply fails the tag check |

## Verification
The bench builds the master with DATA_W=16, DIV_W=16, GAP_W=8 and MIN_HALF=4. The low floor keeps frames short enough for dozens of pipelined replies. It also lets a half-period setting of 1 show the clamp at work, while a setting of 6 shows an unclamped divider. The 16-bit result width exercises the sign-extension variant of the decoder. The 8-bit gap input allows a 20-cycle idle that is far longer than the handshake latency, so the gap length can be measured exactly. A sensor model in the bench reproduces the one-frame configuration lag and both codings, and it can corrupt the tag of a chosen frame.

// File: rtl/spoll_pkg.sv
package spoll_pkg;

   localparam int WORD_W     = 16;
   localparam int FRAME_BITS = 16;
   localparam int SAMPLE_W   = 12;
   localparam int TAG_LSB    = 12;
   localparam int NUM_SRC    = 4;

   typedef logic [$clog2(NUM_SRC)-1:0] src_t;

   typedef enum logic [2:0] {
      FS_QUIET,
      FS_SETUP,
      FS_HIGH,
      FS_LOW,
      FS_TAIL
   } fstate_e;

   // Command: write flag set, fixed-high pair at 9:8, source at 11:10, coding at 4.
   function automatic logic [WORD_W-1:0] build_cmd(input src_t src, input logic offset_bin);
      logic [WORD_W-1:0] w;
      w        = '0;
      w[15]    = 1'b1;
      w[11:10] = src;
      w[9:8]   = 2'b11;
      w[4]     = offset_bin;
      return w;
   endfunction

endpackage

// File: rtl/spoll_frame.sv
module spoll_frame
   import spoll_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int GAP_W    = 8,
   parameter int MIN_HALF = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_i,
   input  logic [GAP_W-1:0]  gap_i,
   input  logic              start_i,
   input  logic [WORD_W-1:0] cmd_i,
   input  logic              miso_i,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              launch_o,
   output logic              done_o,
   output logic [WORD_W-1:0] rx_o
);

   localparam int CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;
   localparam int BIT_W = $clog2(FRAME_BITS + 1);
   localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

   generate
      if (MIN_HALF < 1) begin : g_bad_min
         $error("spoll_frame: MIN_HALF must be at least 1");
      end
      if (DIV_W < 2 || GAP_W < 1) begin : g_bad_w
         $error("spoll_frame: counter widths too small");
      end
   endgenerate

   fstate_e           st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BIT_W-1:0]  bits_q;
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;
   logic              cs_n_q;
   logic              sclk_q;
   logic              done_q;
   logic [DIV_W-1:0]  half_eff;
   logic [CNT_W-1:0]  reload;
   logic              cnt_zero;

   always_comb begin
      half_eff = (half_i < MIN_H) ? MIN_H : half_i;
   end

   assign reload   = CNT_W'(half_eff) - CNT_W'(1);
   assign cnt_zero = (cnt_q == '0);
   assign launch_o = (st_q == FS_QUIET) && cnt_zero && start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_QUIET;
         cnt_q  <= '0;
         bits_q <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         cs_n_q <= 1'b1;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            FS_QUIET: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end else if (start_i) begin
                  st_q   <= FS_SETUP;
                  cs_n_q <= 1'b0;
                  tx_q   <= cmd_i;
                  bits_q <= '0;
                  cnt_q  <= reload;
               end
            end
            FS_SETUP, FS_LOW: begin
               if (cnt_zero) begin
                  st_q   <= FS_HIGH;
                  sclk_q <= 1'b1;
                  rx_q   <= {rx_q[WORD_W-2:0], miso_i};
                  bits_q <= bits_q + BIT_W'(1);
                  cnt_q  <= reload;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            FS_HIGH: begin
               if (cnt_zero) begin
                  sclk_q <= 1'b0;
                  cnt_q  <= reload;
                  if (bits_q == BIT_W'(FRAME_BITS)) begin
                     st_q <= FS_TAIL;
                  end else begin
                     st_q <= FS_LOW;
                     tx_q <= {tx_q[WORD_W-2:0], 1'b0};
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            FS_TAIL: begin
               if (cnt_zero) begin
                  st_q   <= FS_QUIET;
                  cs_n_q <= 1'b1;
                  done_q <= 1'b1;
                  cnt_q  <= CNT_W'(gap_i);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: st_q <= FS_QUIET;
         endcase
      end
   end

   assign cs_n_o = cs_n_q;
   assign sclk_o = sclk_q;
   assign mosi_o = cs_n_q ? 1'b0 : tx_q[WORD_W-1];
   assign done_o = done_q;
   assign rx_o   = rx_q;

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o); // R2
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (bits_q == BIT_W'(FRAME_BITS))); // R2

endmodule

// File: rtl/spoll_decode.sv
module spoll_decode
   import spoll_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                     [WORD_W-1:0] word_i,
   input  src_t                                  exp_src_i,
   input  logic                                  offset_i,
   output logic                                  tag_ok_o,
   output src_t                                  tag_o,
   output logic signed [DATA_W-1:0]              value_o
);

   generate
      if (DATA_W < SAMPLE_W) begin : g_bad_data_w
         $error("spoll_decode: DATA_W must hold a 12-bit sample");
      end
   endgenerate

   logic [SAMPLE_W-1:0] raw;
   logic [SAMPLE_W-1:0] s12;

   assign raw      = word_i[SAMPLE_W-1:0];
   assign tag_o    = word_i[TAG_LSB +: $bits(src_t)];
   assign tag_ok_o = (word_i[WORD_W-1:TAG_LSB+$bits(src_t)] == '0) && (tag_o == exp_src_i);

   // Offset binary minus half scale is the same as flipping the top bit.
   assign s12 = offset_i ? {~raw[SAMPLE_W-1], raw[SAMPLE_W-2:0]} : raw;

   generate
      if (DATA_W > SAMPLE_W) begin : g_extend
         assign value_o = {{(DATA_W-SAMPLE_W){s12[SAMPLE_W-1]}}, s12};
      end else begin : g_exact
         assign value_o = s12;
      end
   endgenerate

endmodule

// File: rtl/spoll_master.sv
module spoll_master
   import spoll_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int DIV_W    = 16,
   parameter int GAP_W    = 8,
   parameter int MIN_HALF = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DIV_W-1:0]         half_div_i,
   input  logic [GAP_W-1:0]         gap_i,
   input  logic                     offset_bin_i,
   output logic                     sclk_o,
   output logic                     cs_n_o,
   output logic                     mosi_o,
   input  logic                     miso_i,
   output logic                     res_valid_o,
   input  logic                     res_ready_i,
   output logic [1:0]               res_chan_o,
   output logic signed [DATA_W-1:0] res_value_o,
   output logic                     seq_err_o
);

   generate
      if (NUM_SRC != 4) begin : g_bad_src
         $error("spoll_master: channel port assumes four sources");
      end
   endgenerate

   logic              launch;
   logic              done;
   logic              start_ok;
   logic [WORD_W-1:0] rx_word;
   logic [WORD_W-1:0] cmd_word;

   src_t rr_q;
   src_t sent_src_q;
   logic sent_cod_q;
   logic sent_vld_q;
   src_t exp_src_q;
   logic exp_cod_q;
   logic exp_vld_q;

   logic                     tag_ok;
   src_t                     tag;
   logic signed [DATA_W-1:0] value;

   logic                     res_valid_q;
   src_t                     res_chan_q;
   logic signed [DATA_W-1:0] res_value_q;
   logic                     err_q;

   // A frame may begin only when nothing is held and no reply is being stored.
   assign start_ok = !res_valid_q && !done;
   assign cmd_word = build_cmd(rr_q, offset_bin_i);

   spoll_frame #(
      .DIV_W   (DIV_W),
      .GAP_W   (GAP_W),
      .MIN_HALF(MIN_HALF)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .half_i  (half_div_i),
      .gap_i   (gap_i),
      .start_i (start_ok),
      .cmd_i   (cmd_word),
      .miso_i  (miso_i),
      .cs_n_o  (cs_n_o),
      .sclk_o  (sclk_o),
      .mosi_o  (mosi_o),
      .launch_o(launch),
      .done_o  (done),
      .rx_o    (rx_word)
   );

   spoll_decode #(
      .DATA_W(DATA_W)
   ) u_decode (
      .word_i   (rx_word),
      .exp_src_i(exp_src_q),
      .offset_i (exp_cod_q),
      .tag_ok_o (tag_ok),
      .tag_o    (tag),
      .value_o  (value)
   );

   // Two-stage source pipeline: what was just sent, and what the reply in flight belongs to.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q       <= '0;
         sent_src_q <= '0;
         sent_cod_q <= 1'b0;
         sent_vld_q <= 1'b0;
         exp_src_q  <= '0;
         exp_cod_q  <= 1'b0;
         exp_vld_q  <= 1'b0;
      end else if (launch) begin
         exp_src_q  <= sent_src_q;
         exp_cod_q  <= sent_cod_q;
         exp_vld_q  <= sent_vld_q;
         sent_src_q <= rr_q;
         sent_cod_q <= offset_bin_i;
         sent_vld_q <= 1'b1;
         rr_q       <= rr_q + src_t'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_q <= 1'b0;
         res_chan_q  <= '0;
         res_value_q <= '0;
         err_q       <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (res_valid_q && res_ready_i) begin
            res_valid_q <= 1'b0;
         end
         if (done && exp_vld_q) begin
            if (tag_ok) begin
               res_valid_q <= 1'b1;
               res_chan_q  <= tag;
               res_value_q <= value;
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

   assign res_valid_o = res_valid_q;
   assign res_chan_o  = res_chan_q;
   assign res_value_o = res_value_q;
   assign seq_err_o   = err_q;

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> cs_n_o); // R7
   AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_value_o) && $stable(res_chan_o))); // R7
   AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err_o |-> !res_valid_o); // R5
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err_o |=> !seq_err_o); // R5

endmodule

// File: tb/tb_spoll_master.sv
`timescale 1ns/100ps
module tb_spoll_master;

   localparam int DATA_W = 16;
   localparam int DIV_W  = 16;
   localparam int GAP_W  = 8;
   localparam int MIN_H  = 4;
   localparam int NV     = 16;

   // {coding of command n, raw 12-bit sample returned for result n, expected signed result}
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 12'h4CE, 16'h04CE}, {1'b1, 12'hE41, 16'hFE41},
      {1'b0, 12'h666, 16'h0666}, {1'b1, 12'hFFF, 16'hFFFF},
      {1'b1, 12'h800, 16'hF800}, {1'b0, 12'h7FF, 16'h07FF},
      {1'b1, 12'h000, 16'h0000}, {1'b0, 12'h001, 16'h0001},
      {1'b0, 12'hB32, 16'hFB32}, {1'b1, 12'h19D, 16'h019D},
      {1'b1, 12'h7FF, 16'h07FF}, {1'b0, 12'h800, 16'hF800},
      {1'b1, 12'h001, 16'h0001}, {1'b0, 12'hFFE, 16'hFFFE},
      {1'b0, 12'h123, 16'h0123}, {1'b1, 12'hABC, 16'hFABC}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [DIV_W-1:0]         half_div;
   logic [GAP_W-1:0]         gap;
   logic                     offset_bin;
   logic                     miso;
   logic                     res_ready;
   logic                     sclk_o, cs_n_o, mosi_o, res_valid_o, seq_err_o;
   logic [1:0]               res_chan_o;
   logic signed [DATA_W-1:0] res_value_o;

   spoll_master #(
      .DATA_W  (DATA_W),
      .DIV_W   (DIV_W),
      .GAP_W   (GAP_W),
      .MIN_HALF(MIN_H)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .half_div_i  (half_div),
      .gap_i       (gap),
      .offset_bin_i(offset_bin),
      .sclk_o      (sclk_o),
      .cs_n_o      (cs_n_o),
      .mosi_o      (mosi_o),
      .miso_i      (miso),
      .res_valid_o (res_valid_o),
      .res_ready_i (res_ready),
      .res_chan_o  (res_chan_o),
      .res_value_o (res_value_o),
      .seq_err_o   (seq_err_o)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic vec_cod(input int n);
      logic [11:0] t;
      t = 12'(n);
      return (n < NV) ? VEC[n][28] : t[0];
   endfunction

   function automatic logic [11:0] vec_raw(input int n);
      return (n < NV) ? VEC[n][27:16] : 12'(n * 37 + 5);
   endfunction

   function automatic logic [15:0] vec_exp(input int n);
      logic [11:0] r;
      r = vec_raw(n);
      return (n < NV) ? VEC[n][15:0] : {{4{r[11]}}, r};
   endfunction

   function automatic logic [15:0] exp_cmd(input int n);
      return {2'b10, 2'b00, 2'(n % 4), 2'b11, 3'b000, vec_cod(n), 4'b0000};
   endfunction

   // Sensor model: reply reflects the configuration written by the previous complete frame.
   int          frame_idx = 0;
   int          cur = 0;
   int          bad_frame = -1;
   int          frame_bits_bad = 0;
   int          rbits = 0;
   logic [1:0]  cfg_src = 2'b00;
   logic        cfg_cod = 1'b0;
   logic [15:0] sh = '0;
   logic [15:0] rxc = '0;
   logic [15:0] cmd_log [64];

   always @(negedge cs_n_o) begin
      cur = frame_idx;
      if (cur == 0) begin
         sh = 16'h2ABC;
      end else begin
         sh = {2'b00, cfg_src ^ ((cur == bad_frame) ? 2'b01 : 2'b00),
               cfg_cod ? (vec_raw(cur - 1) + 12'h800) : vec_raw(cur - 1)};
      end
      miso = sh[15];
      rbits = 0;
      rxc = '0;
      frame_idx++;
      offset_bin = vec_cod(frame_idx);
   end

   always @(negedge sclk_o) begin
      if (!cs_n_o) begin
         sh = {sh[14:0], 1'b0};
         miso = sh[15];
      end
   end

   always @(posedge sclk_o) begin
      if (!cs_n_o) begin
         rxc = {rxc[14:0], mosi_o};
         rbits++;
      end
   end

   always @(posedge cs_n_o) begin
      if (rst_n) begin
         if (rbits == 16 && rxc[15]) begin
            cfg_src = rxc[11:10];
            cfg_cod = rxc[4];
         end
         if (cur < 64) cmd_log[cur] = rxc;
         if (rbits != 16) frame_bits_bad++;
      end
   end

   // Result monitor
   int exp_n = 0;
   int skip_n = -1;
   int err_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (seq_err_o) err_seen++;
         if (res_valid_o && res_ready) begin
            if (exp_n == skip_n) exp_n++;
            chk(res_chan_o == 2'(exp_n % 4), "R4", "result channel", int'(res_chan_o), exp_n % 4);
            chk($unsigned(res_value_o) == vec_exp(exp_n), "R6", "result value",
                int'(res_value_o), int'($signed(vec_exp(exp_n))));
            exp_n++;
         end
      end
   end

   task automatic wait_res(input int k);
      while (exp_n < k) @(negedge clk);
   endtask

   task automatic drive_slot();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int hi;
      int bad;
      int cap_chan;
      int cap_val;
      half_div   = 16'd6;
      gap        = 8'd3;
      offset_bin = vec_cod(0);
      miso       = 1'b0;
      res_ready  = 1'b1;

      repeat (4) @(negedge clk);
      chk(cs_n_o == 1'b1, "R1", "cs_n in reset", int'(cs_n_o), 1);
      chk(sclk_o == 1'b0, "R1", "sclk in reset", int'(sclk_o), 0);
      chk(res_valid_o == 1'b0 && seq_err_o == 1'b0, "R1", "valid/err in reset",
          int'(res_valid_o) + int'(seq_err_o), 0);
      drive_slot();
      rst_n = 1'b1;

      // R8: unclamped half period
      @(posedge sclk_o);
      hi = 0;
      @(negedge clk);
      while (sclk_o) begin hi++; @(negedge clk); end
      chk(hi == 6, "R8", "sclk high clocks", hi, 6);

      // Vector walk: results checked by the monitor, command words checked here
      for (int n = 0; n < NV; n++) begin
         wait_res(n + 1);
         chk(cmd_log[n] == exp_cmd(n), "R3", "command word", int'(cmd_log[n]), int'(exp_cmd(n)));
      end
      chk(err_seen == 0, "R4", "first reply discarded without error", err_seen, 0);
      chk(frame_bits_bad == 0, "R2", "frames with wrong clock count", frame_bits_bad, 0);

      // R7: stalled result port holds off the next frame
      drive_slot();
      res_ready = 1'b0;
      @(negedge clk);
      while (!res_valid_o) @(negedge clk);
      cap_chan = int'(res_chan_o);
      cap_val  = int'(res_value_o);
      bad = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!cs_n_o || !res_valid_o || int'(res_chan_o) != cap_chan || int'(res_value_o) != cap_val) bad++;
      end
      chk(bad == 0, "R7", "cycles violating hold-off", bad, 0);
      drive_slot();
      res_ready = 1'b1;
      wait_res(NV + 2);

      // R8: setting below the floor is clamped
      drive_slot();
      half_div = 16'd1;
      @(posedge cs_n_o);
      @(posedge sclk_o);
      hi = 0;
      @(negedge clk);
      while (sclk_o) begin hi++; @(negedge clk); end
      chk(hi == MIN_H, "R8", "clamped sclk high clocks", hi, MIN_H);

      // R9: quiet gap
      drive_slot();
      gap = 8'd20;
      @(posedge cs_n_o);
      @(posedge cs_n_o);
      hi = 0;
      @(negedge clk);
      while (cs_n_o) begin hi++; @(negedge clk); end
      chk(hi == 21, "R9", "chip select idle clocks", hi, 21);

      // R5: corrupt the tag of one frame
      drive_slot();
      bad_frame = frame_idx + 1;
      skip_n    = bad_frame - 1;
      wait_res(skip_n + 3);
      chk(err_seen == 1, "R5", "error pulse cycles", err_seen, 1);
      chk(frame_bits_bad == 0, "R2", "frames with wrong clock count", frame_bits_bad, 0);

      finished = 1;
      summary();
      $finish;
   end

endmodule